// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a host and a battery-backed static RAM. It passes the host's active-low chip-enable to the memory only while the supply is in tolerance, and forces it inactive otherwise. A digital power-good flag from an external voltage comparator tells the block whether the supply is valid. That flag is asynchronous, so the block resynchronises it before acting on it.

When power drops while the host has an access open, the block lets that access finish. It does not let it run forever, though: after a write-protect timeout the memory is deselected whatever the host does. When power comes back, the block keeps the memory deselected for a long recovery period so the host can settle. A status flag reports whenever the memory is being guarded rather than passed through.

Both windows are set in time units and turned into clock cycles from a clock-frequency parameter. The block treats the host enable as synchronous to its clock.

Top module: `pfg_ce_gate`

## Requirements
- R1: While reset is high and afterwards, `mem_ce_n` and `wp_active` are 1. With `pwr_good_async` held at 1 through reset, `mem_ce_n` first follows `host_ce_n` after clock edge REC_CYC+3, counting the first edge with reset low as edge 1.
- R2: In the normal state, `mem_ce_n` equals the value that `host_ce_n` had at the previous clock edge, and `wp_active` is 0.
- R3: If `pwr_good_async` falls before edge 1 and `host_ce_n` is 1 when the fall reaches the control logic at edge 3, `mem_ce_n` stays 1 from then on, even if the host asserts its enable later.
- R4: If `host_ce_n` is 0 when the fall is seen at edge 3, `mem_ce_n` stays 0 until the first edge at which `host_ce_n` is sampled 1. From that edge on it stays 1, and a later host assertion is not passed through.
- R5: An access that is still in flight is cut off at edge 3+WP_CYC. WP_CYC = CLK_KHZ*WP_TIMEOUT_NS/1,000,000, with a minimum of 1.
- R6: If `pwr_good_async` rises before edge 1 while power is failed, `mem_ce_n` is held at 1 through edge REC_CYC+2, whatever `host_ce_n` does. From edge REC_CYC+3 it follows the host again. REC_CYC = CLK_KHZ*RECOVER_US/1000, with a minimum of 1.
- R7: Suppose power is good before edge 1, drops before edge f and returns before edge f+1, with f ≤ REC_CYC. Then the recovery count restarts, and `mem_ce_n` first follows the host after edge f+3+REC_CYC.
- R8: `wp_active` is 1 exactly when the block is not in its normal pass-through state. It changes at the same edge as the state change that decides `mem_ce_n`.
- R9: `pwr_good_async` passes through a two-stage synchronizer. A change on it reaches the control state at the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_async | input | 1 | Supply-in-tolerance flag from the comparator, asynchronous |
| host_ce_n | input | 1 | Host chip-enable, active low |
| mem_ce_n | output | 1 | Conditioned chip-enable to the memory, active low, registered |
| wp_active | output | 1 | High while the memory is guarded, registered |

## Verification
Every result is due a fixed number of edges after its stimulus:
- Host pass-through appears one edge after the host value is sampled.
- A power-good change acts at the third edge (two synchronizer stages plus the state register).
- The drain cutoff lands WP_CYC edges after that.
- The end of recovery lands REC_CYC edges after that.

The bench changes inputs only on falling clock edges and counts rising edges from the stimulus. After every edge it compares both outputs against the edge index at which the change is due, so a result that comes one cycle early or late is flagged. The drain sweep moves the host release across every edge from before detection to past the timeout. The recovery-interrupt sweep moves the power dip from the start to the last cycle of recovery.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfg_state_e;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  // Reset to "power not good" so nothing is trusted until seen twice.
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/pfg_timer.sv
module pfg_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  // Loaded on the entering edge, so expiry is seen in the CYCLES-th cycle.
  always_ff @(posedge clk) begin
    if (rst || load)      cnt <= TOP;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
  import pfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       host_ce_n,
  input  logic       drain_expired,
  input  logic       rec_expired,
  output pfg_state_e state_q,
  output pfg_state_e state_nxt,
  output logic       drain_load,
  output logic       rec_load
);

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (!pwr_ok) state_nxt = host_ce_n ? ST_PROTECT : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (host_ce_n || drain_expired) state_nxt = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (pwr_ok) state_nxt = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!pwr_ok)          state_nxt = ST_PROTECT;
        else if (rec_expired) state_nxt = ST_NORMAL;
      end
      default: state_nxt = ST_PROTECT;
    endcase
  end

  assign drain_load = (state_nxt == ST_DRAIN)   && (state_q != ST_DRAIN);
  assign rec_load   = (state_nxt == ST_RECOVER) && (state_q != ST_RECOVER);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RECOVER;
    else     state_q <= state_nxt;
  end

endmodule

// File: rtl/pfg_ce_gate.sv
module pfg_ce_gate
  import pfg_pkg::*;
#(
  parameter int unsigned CLK_KHZ       = 125000,
  parameter int unsigned WP_TIMEOUT_NS = 150000,
  parameter int unsigned RECOVER_US    = 200000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_async,
  input  logic host_ce_n,
  output logic mem_ce_n,
  output logic wp_active
);

  localparam longint unsigned WP_RAW  =
    (64'(CLK_KHZ) * 64'(WP_TIMEOUT_NS)) / 64'd1000000;
  localparam longint unsigned REC_RAW =
    (64'(CLK_KHZ) * 64'(RECOVER_US)) / 64'd1000;
  localparam int unsigned WP_CYC  = (WP_RAW  < 64'd1) ? 1 : 32'(WP_RAW);
  localparam int unsigned REC_CYC = (REC_RAW < 64'd1) ? 1 : 32'(REC_RAW);

  logic       pwr_ok;
  logic       drain_expired, rec_expired;
  logic       drain_load, rec_load;
  pfg_state_e state_q, state_nxt;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_good_async),
    .q   (pwr_ok)
  );

  pfg_timer #(.CYCLES(WP_CYC)) u_drain_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (drain_load),
    .expired (drain_expired)
  );

  pfg_timer #(.CYCLES(REC_CYC)) u_rec_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (rec_load),
    .expired (rec_expired)
  );

  pfg_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .pwr_ok        (pwr_ok),
    .host_ce_n     (host_ce_n),
    .drain_expired (drain_expired),
    .rec_expired   (rec_expired),
    .state_q       (state_q),
    .state_nxt     (state_nxt),
    .drain_load    (drain_load),
    .rec_load      (rec_load)
  );

  // Outputs are registered from the next state so they change together with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n  <= 1'b1;
      wp_active <= 1'b1;
    end else begin
      mem_ce_n  <= ((state_nxt == ST_NORMAL) || (state_nxt == ST_DRAIN)) ? host_ce_n : 1'b1;
      wp_active <= (state_nxt != ST_NORMAL);
    end
  end

endmodule

// File: rtl/pfg_ce_gate_chk.sv
module pfg_ce_gate_chk
  import pfg_pkg::*;
#(
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned REC_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       host_ce_n,
  input logic       mem_ce_n,
  input logic       wp_active,
  input pfg_state_e state
);

  int unsigned drain_cnt;
  int unsigned rec_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_cnt <= 0;
      rec_cnt   <= 0;
    end else begin
      drain_cnt <= (state == ST_DRAIN)   ? drain_cnt + 1 : 0;
      rec_cnt   <= (state == ST_RECOVER) ? rec_cnt + 1   : 0;
    end
  end

  assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NORMAL) |-> (mem_ce_n == $past(host_ce_n)));

  assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROTECT) |-> mem_ce_n);

  assert_drain_entry_R4: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DRAIN) && ($past(state) != ST_DRAIN))
      |-> (($past(state) == ST_NORMAL) && !$past(host_ce_n)));

  assert_drain_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> (drain_cnt < WP_CYC));

  assert_recover_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOVER) |-> mem_ce_n);

  assert_recover_len_R6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_NORMAL) && ($past(state) == ST_RECOVER)) |-> (rec_cnt == REC_CYC));

  assert_normal_entry_R7: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_NORMAL) && ($past(state) != ST_NORMAL)) |-> ($past(state) == ST_RECOVER));

  assert_flag_R8: assert property (@(posedge clk) disable iff (rst)
    !wp_active |-> (state == ST_NORMAL));

endmodule

bind pfg_ce_gate pfg_ce_gate_chk #(.WP_CYC(WP_CYC), .REC_CYC(REC_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_ce_n (host_ce_n),
  .mem_ce_n  (mem_ce_n),
  .wp_active (wp_active),
  .state     (state_q)
);

// File: tb/tb_pfg_ce_gate.sv
`timescale 1ns/1ps
module tb_pfg_ce_gate;

  localparam int unsigned CLK_KHZ = 125000;
  localparam int unsigned WP_NS   = 80;
  localparam int unsigned REC_US  = 1;
  localparam int WPN  = (CLK_KHZ * WP_NS) / 1000000;   // 10
  localparam int RECN = (CLK_KHZ * REC_US) / 1000;     // 125

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg  = 1'b1;
  logic ce_in = 1'b0;
  logic ce_out, wp;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfg_ce_gate #(
    .CLK_KHZ(CLK_KHZ), .WP_TIMEOUT_NS(WP_NS), .RECOVER_US(REC_US)
  ) dut (
    .clk(clk), .rst(rst), .pwr_good_async(pg),
    .host_ce_n(ce_in), .mem_ce_n(ce_out), .wp_active(wp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Power already good before edge 1 (or restored): held off until edge RECN+3.
  task automatic recover_check(input string req);
    for (int j = 1; j <= RECN + 3; j++) begin
      ce_in = (j < RECN + 3) ? logic'(j % 2) : 1'b0;
      step();
      chk(req, ce_out, (j >= RECN + 3) ? 1'b0 : 1'b1);
      chk("R8", wp, (j >= RECN + 3) ? 1'b0 : 1'b1);
    end
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1; pg = 1'b1; ce_in = 1'b0;
    repeat (3) begin
      step();
      chk("R1", ce_out, 1'b1);
      chk("R1", wp, 1'b1);
    end
    rst = 1'b0;
    recover_check("R1");

    // R2: pass-through of a pseudo-random host pattern
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 120; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ce_in = lfsr[0];
        step();
        chk("R2", ce_out, lfsr[0]);
        chk("R2", wp, 1'b0);
      end
    end

    // R3 / R9: idle host at detection, later host assertion is blocked
    ce_in = 1'b1;
    pg = 1'b0;
    for (int j = 1; j <= 12; j++) begin
      ce_in = (j >= 4) ? 1'b0 : 1'b1;
      step();
      chk("R3", ce_out, 1'b1);
      chk("R9", wp, (j >= 3) ? 1'b1 : 1'b0);
    end
    pg = 1'b1;
    recover_check("R6");

    // R4 / R5: drain sweep over the edge at which the host releases
    for (int e = 1; e <= WPN + 5; e++) begin
      int first_high;
      first_high = (e < 3) ? e : ((e < 3 + WPN) ? e : 3 + WPN);
      ce_in = 1'b0;
      pg = 1'b0;
      for (int j = 1; j <= WPN + 6; j++) begin
        if (j >= e) ce_in = 1'b1;
        step();
        chk((e >= 3 + WPN) ? "R5" : "R4", ce_out, (j >= first_high) ? 1'b1 : 1'b0);
        chk("R8", wp, (j >= 3) ? 1'b1 : 1'b0);
      end
      ce_in = 1'b0;
      repeat (4) begin
        step();
        chk("R4", ce_out, 1'b1);
      end
      pg = 1'b1;
      recover_check("R6");
    end

    // R7: power dip during recovery restarts the count
    begin
      int fl [4] = '{2, 10, 60, RECN};
      foreach (fl[k]) begin
        int f;
        f = fl[k];
        ce_in = 1'b1;
        pg = 1'b0;
        repeat (6) step();
        pg = 1'b1;
        for (int j = 1; j <= f + 3 + RECN; j++) begin
          if (j == f)     pg = 1'b0;
          if (j == f + 1) pg = 1'b1;
          ce_in = 1'b0;
          step();
          chk("R7", ce_out, (j >= f + 3 + RECN) ? 1'b0 : 1'b1);
        end
        step();
        chk("R7", wp, 1'b0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule